// File: doc/BRIEF.md
# CAN Controller Configuration Guard

This block keeps the configuration registers of a CAN controller and shields them from writes made at the wrong time. Software reaches it through a plain register bus: a write strobe, a 6-bit address, write data and combinational read data. The controller's set-up registers accept writes only after software has asked for initialization mode and seen the acknowledge come back. The module enable bit takes exactly one write per reset. The error counters can be read but not written.

The block also makes the time-quantum timing for the protocol engine. It selects the CAN clock from either the oscillator clock or the bus clock, then divides it by a programmable factor of 1 to 64. The result is a one-cycle enable pulse in the CAN clock domain. While the controller is in initialization or power-down, the transmit line from the protocol engine is replaced by a recessive level.

Top module: `can_cfg_guard`

## Requirements
- R1: After reset, control register 0 (address 0x00) reads 0x01 with the init request set, control register 1 (address 0x01) reads 0x01 with the acknowledge set, every other register reads 0, `init_ack` is 1 and `tx_out` is 1.
- R2: `init_ack`, which is also readable as bit 0 of address 0x01, takes the value of the init request (bit 0 of address 0x00) two bus clocks later, on entry and on exit alike.
- R3: The locked registers are timing 0 (0x02), timing 1 (0x03), acceptance control (0x04), eight code registers (0x08 to 0x0F) and eight mask registers (0x10 to 0x17), together with bits 6:1 of address 0x01. They take a write only in a cycle where `init_ack` is 1; at any other time a write leaves them unchanged.
- R4: Address 0x00 can be written at any time. Bit 0 is the init request and bit 1 is the power-down request; the other bits read 0.
- R5: Bit 7 of address 0x01 is the module enable. It is set only by the first accepted write to 0x01 after reset, and later writes leave it unchanged.
- R6: Addresses 0x06 and 0x07 read the transmit and receive error counter inputs, and writes to them have no effect.
- R7: Any address not listed in R3, R4 or R6 (for example 0x05, 0x18 to 0x3F) reads 0.
- R8: `tx_out` is 1 whenever the init request, `init_ack` or the power-down request is set; otherwise it equals `tx_in`.
- R9: Bit 6 of address 0x01 selects the CAN clock: 0 for `osc_clk`, 1 for `bus_clk`.
- R10: With the enable set, `init_ack` at 0 and power-down clear, `tq_en` pulses once every N+1 CAN clock cycles, where N is bits 5:0 of address 0x02. In initialization mode `tq_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock, one of the two CAN clock sources |
| osc_clk | input | 1 | Oscillator clock, the other CAN clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tx_err_cnt | input | 8 | Transmit error counter value |
| rx_err_cnt | input | 8 | Receive error counter value |
| tx_in | input | 1 | Transmit bit from the protocol engine |
| tx_out | output | 1 | Transmit line toward the transceiver |
| init_ack | output | 1 | Initialization mode acknowledge |
| tq_en | output | 1 | Time-quantum enable, CAN clock domain |

## Verification
Read data and `tx_out` follow their inputs in the same cycle. A register write shows up in read data from the next bus clock. `init_ack` moves two bus clocks after the request bit is written, and the time-quantum counter starts a further two CAN clocks after `init_ack` falls. The bench drives inputs on the falling bus edge and compares every output against its model 1 ns later, so each value is checked in the cycle it becomes due. Prescaler checks wait for a steady pulse train and then measure the third gap on the selected clock, which keeps the synchronizer start-up out of the count.

// File: rtl/can_cfg_guard.sv
module can_cfg_guard #(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int PW    = 6,
  parameter int NFILT = 8
) (
  input  logic          bus_clk,
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] tx_err_cnt,
  input  logic [DW-1:0] rx_err_cnt,
  input  logic          tx_in,
  output logic          tx_out,
  output logic          init_ack,
  output logic          tq_en
);
  localparam int FW = $clog2(NFILT);
  localparam logic [AW-1:0] A_CTL0 = AW'(0);
  localparam logic [AW-1:0] A_CTL1 = AW'(1);
  localparam logic [AW-1:0] A_BT0  = AW'(2);
  localparam logic [AW-1:0] A_BT1  = AW'(3);
  localparam logic [AW-1:0] A_ACC  = AW'(4);
  localparam logic [AW-1:0] A_TXE  = AW'(6);
  localparam logic [AW-1:0] A_RXE  = AW'(7);
  localparam int CODE_BASE = 8;
  localparam int MASK_BASE = CODE_BASE + NFILT;

  logic          init_req, pdn_req, ack_s1;
  logic          mod_en, en_done, clk_src;
  logic [5:1]    ctl1_mid;
  logic [DW-1:0] bt0, bt1, acc;
  logic [DW-1:0] code_r [NFILT];
  logic [DW-1:0] mask_r [NFILT];

  wire in_code = (int'(addr) >= CODE_BASE) && (int'(addr) < MASK_BASE);
  wire in_mask = (int'(addr) >= MASK_BASE) && (int'(addr) < MASK_BASE + NFILT);
  wire [FW-1:0] fidx = FW'(addr);
  wire cfg_wr = wr_en && init_ack;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req <= 1'b1;
      pdn_req  <= 1'b0;
      ack_s1   <= 1'b1;
      init_ack <= 1'b1;
    end else begin
      if (wr_en && addr == A_CTL0) begin
        init_req <= wdata[0];
        pdn_req  <= wdata[1];
      end
      ack_s1   <= init_req;
      init_ack <= ack_s1;
    end
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en   <= 1'b0;
      en_done  <= 1'b0;
      clk_src  <= 1'b0;
      ctl1_mid <= '0;
      bt0      <= '0;
      bt1      <= '0;
      acc      <= '0;
      for (int i = 0; i < NFILT; i++) begin
        code_r[i] <= '0;
        mask_r[i] <= '0;
      end
    end else if (cfg_wr) begin
      if (addr == A_CTL1) begin
        clk_src  <= wdata[6];
        ctl1_mid <= wdata[5:1];
        if (!en_done) begin
          mod_en  <= wdata[7];
          en_done <= 1'b1;
        end
      end
      if (addr == A_BT0) bt0 <= wdata;
      if (addr == A_BT1) bt1 <= wdata;
      if (addr == A_ACC) acc <= wdata;
      if (in_code) code_r[fidx] <= wdata;
      if (in_mask) mask_r[fidx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTL0)      rdata = DW'({pdn_req, init_req});
    else if (addr == A_CTL1) rdata = DW'({mod_en, clk_src, ctl1_mid, init_ack});
    else if (addr == A_BT0)  rdata = bt0;
    else if (addr == A_BT1)  rdata = bt1;
    else if (addr == A_ACC)  rdata = acc;
    else if (addr == A_TXE)  rdata = tx_err_cnt;
    else if (addr == A_RXE)  rdata = rx_err_cnt;
    else if (in_code)        rdata = code_r[fidx];
    else if (in_mask)        rdata = mask_r[fidx];
  end

  assign tx_out = (init_req || init_ack || pdn_req) ? 1'b1 : tx_in;

  wire can_clk = clk_src ? bus_clk : osc_clk;
  wire run     = mod_en && !init_ack && !pdn_req;
  logic          run_s1, run_s2;
  logic [PW-1:0] tq_cnt;
  wire           tq_wrap = (tq_cnt == bt0[PW-1:0]);

  always_ff @(posedge can_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_s1 <= 1'b0;
      run_s2 <= 1'b0;
      tq_cnt <= '0;
    end else begin
      run_s1 <= run;
      run_s2 <= run_s1;
      if (!run_s2 || tq_wrap) tq_cnt <= '0;
      else                    tq_cnt <= tq_cnt + 1'b1;
    end
  end

  assign tq_en = run_s2 && tq_wrap;

  p_bt0_lock_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && addr == A_BT0 && !init_ack) |=> $stable(bt0));

  p_en_once_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
    en_done |=> $stable(mod_en));

  p_ack_rise_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(init_ack) |-> $past(init_req, 2));

  p_ack_fall_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $fell(init_ack) |-> !$past(init_req, 2));

  p_tx_recessive_r8: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (init_ack || pdn_req) |-> tx_out);
endmodule

// File: tb/can_cfg_guard_test.sv
`timescale 1ns/1ps
module can_cfg_guard_test;
  logic bus_clk = 0, osc_clk = 0, rst_n = 0;
  logic wr_en = 0, tx_in = 0;
  logic [5:0] addr = 0;
  logic [7:0] wdata = 0, txe = 8'h12, rxe = 8'h34;
  logic [7:0] rdata;
  logic tx_out, init_ack, tq_en;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 bus_clk = ~bus_clk;
  always #3.5 osc_clk = ~osc_clk;

  can_cfg_guard uut (.bus_clk(bus_clk), .osc_clk(osc_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tx_err_cnt(txe), .rx_err_cnt(rxe),
    .tx_in(tx_in), .tx_out(tx_out), .init_ack(init_ack), .tq_en(tq_en));

  // behavioural model
  bit m_req, m_pdn, m_ack, m_ackd, m_en, m_used, m_cs;
  logic [7:0] m_mem [64];

  always @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= 1; m_pdn <= 0; m_ack <= 1; m_ackd <= 1; m_en <= 0; m_used <= 0; m_cs <= 0;
      for (int i = 0; i < 64; i++) m_mem[i] <= 0;
    end else begin
      m_ackd <= m_req;
      m_ack  <= m_ackd;
      if (wr_en) begin
        if (addr == 0) begin m_req <= wdata[0]; m_pdn <= wdata[1]; end
        else if (m_ack && addr == 1) begin
          m_cs <= wdata[6];
          m_mem[1] <= {1'b0, wdata[6:1], 1'b0};
          if (!m_used) begin m_en <= wdata[7]; m_used <= 1; end
        end
        else if (m_ack && (addr inside {[2:4]} || addr inside {[8:23]})) m_mem[addr] <= wdata;
      end
    end
  end

  function automatic logic [7:0] mread(logic [5:0] a);
    if (a == 0) return {6'b0, m_pdn, m_req};
    if (a == 1) return {m_en, m_mem[1][6:1], m_ack};
    if (a == 6) return txe;
    if (a == 7) return rxe;
    if (a inside {[2:4]} || a inside {[8:23]}) return m_mem[a];
    return 8'h00;
  endfunction

  function automatic string rtag(logic [5:0] a);
    if (a == 0) return "R4";
    if (a == 1) return "R5";
    if (a == 6 || a == 7) return "R6";
    if (a inside {[2:4]} || a inside {[8:23]}) return "R3";
    return "R7";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time); end
  endtask

  always @(negedge bus_clk) if (rst_n && !done) begin
    #1;
    chk(init_ack == m_ack, "R2", init_ack, m_ack);
    chk(tx_out == ((m_req || m_ack || m_pdn) ? 1'b1 : tx_in), "R8", tx_out,
        (m_req || m_ack || m_pdn) ? 1 : tx_in);
    chk(rdata == mread(addr), rtag(addr), rdata, mread(addr));
  end

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge bus_clk); wr_en = 1; addr = a; wdata = d;
    @(negedge bus_clk); wr_en = 0;
  endtask
  task automatic look(logic [5:0] a);
    @(negedge bus_clk); addr = a;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge bus_clk);
  endtask
  task automatic sclk();
    if (m_cs) @(negedge bus_clk); else @(negedge osc_clk);
  endtask

  // R9 R10: measure third gap between tq pulses on the selected clock
  task automatic tq_gap(int exp, string tag);
    int g;
    g = 0;
    for (int k = 0; k < 3; k++) begin
      g = 0;
      do begin sclk(); g++; end while (!tq_en && g < 300);
    end
    chk(g == exp, tag, g, exp);
  endtask

  task automatic tq_quiet(string tag);
    int hits;
    hits = 0;
    repeat (80) begin sclk(); if (tq_en) hits++; end
    chk(hits == 0, tag, hits, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1;
    #1;
    // R1 reset state
    addr = 0; #0.1 chk(rdata == 8'h01, "R1", rdata, 1);
    addr = 1; #0.1 chk(rdata == 8'h01, "R1", rdata, 1);
    addr = 2; #0.1 chk(rdata == 8'h00, "R1", rdata, 0);
    chk(init_ack == 1 && tx_out == 1, "R1", {init_ack, tx_out}, 3);
    // R3 configure in init
    wr(2, 8'h03); wr(3, 8'h5A); wr(4, 8'h11); wr(10, 8'hA5); wr(23, 8'h3C);
    look(2); look(3); look(4); look(10); look(23);
    // R5 enable once
    wr(1, 8'h80); look(1); wr(1, 8'h00); look(1);
    // R6 error counters
    wr(6, 8'hFF); wr(7, 8'hFF); look(6); look(7);
    txe = 8'h9C; look(6);
    // R7 unmapped
    look(5); look(24); look(63);
    // leave init, R2 + R8
    wr(0, 8'h00); idle(4);
    tx_in = 1; idle(1); tx_in = 0; idle(1);
    // R3 locked writes ignored
    wr(2, 8'h3F); look(2); wr(10, 8'h00); look(10); wr(1, 8'h40); look(1);
    // R10 on oscillator clock, N=3
    tq_gap(4, "R10");
    // power-down R8 R10
    wr(0, 8'h02); idle(3); tq_quiet("R10"); wr(0, 8'h00); idle(3);
    // R9 bus clock, N=0
    wr(0, 8'h01); idle(4); tq_quiet("R10");
    wr(1, 8'h40); wr(2, 8'h00); look(1);
    wr(0, 8'h00); idle(4);
    tq_gap(1, "R9");
    // N=63 on oscillator
    wr(0, 8'h01); idle(4);
    wr(1, 8'h00); wr(2, 8'h3F); look(2);
    wr(0, 8'h00); idle(4);
    tq_gap(64, "R10");
    tx_in = 1; idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule